// File: doc/BRIEF.md
# Serial Clock Divider Search Unit

This block turns a main clock frequency and a requested serial clock frequency into the setting of a two-stage clock divider. The first stage is a power-of-two prescaler selected by a 2-bit exponent. The second stage is a 6-bit baud divisor. Together they produce a serial clock of `main / (2 << exp) / (2 * (baud + 1))`. The exponent may only take the values 0 to 3, and the baud divisor only the values 4 to 63. Requests that lie outside that span are clamped to the fastest or to the slowest legal setting.

A one-cycle `start` pulse captures both frequencies. The unit then performs three jobs on one shared restoring shift-subtract divider, which produces one quotient bit per cycle:

- It computes the ratio `main / request`.
- It walks the exponent upward, one step per cycle, until the shifted ratio fits the baud range.
- It derives the highest and the lowest serial clock that the given main clock allows.

When all of these are ready, `done` pulses for one cycle. The results then stay on the outputs until the next run.

Top module: `spibaud_calc`

## Requirements
- R1: After reset, `busy` and `done` are low, and `div_sel`, `brg_sel`, `cfg_word`, `f_max_hz` and `f_min_hz` are all zero.
- R2: A `start` pulse while idle raises `busy` from the next cycle. `busy` stays high until the cycle in which `done` pulses. In that cycle `busy` is low, and `done` is high for exactly one cycle.
- R3: With `t = floor(main / request)` and `q(e) = floor(t / 2^(e+2))`, the result takes the smallest exponent `e` in 0..3 for which `5 <= q(e) <= 64`, with `brg_sel = q(e) - 1`.
- R4: When `q(0) < 5` (the request is too fast), the result is exponent 0 and baud 4.
- R5: When `q(e) > 64` for every exponent from 0 to 3 (the request is too slow), the result is exponent 3 and baud 63.
- R6: A request of 0 gives exponent 3 and baud 63 without any ratio division. Its `done` arrives at least 32 cycles earlier than the `done` of a nonzero request with the same main clock.
- R7: When `done` pulses, `f_max_hz` equals `floor(main / 20)`.
- R8: When `done` pulses, `f_min_hz` equals `floor(main / 2049) + 1`.
- R9: `cfg_word` packs the exponent in bits [7:6] and the baud divisor in bits [5:0]. `div_sel` and `brg_sel` carry the same two fields separately.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The run in progress finishes with results computed from the inputs it captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a calculation |
| mclk_hz | input | 32 | Main clock frequency in Hz |
| sclk_hz | input | 32 | Requested serial clock frequency in Hz |
| busy | output | 1 | High while a calculation runs |
| done | output | 1 | One-cycle pulse when the results are valid |
| div_sel | output | 2 | Chosen prescaler exponent |
| brg_sel | output | 6 | Chosen baud divisor |
| cfg_word | output | 8 | Packed {exponent, baud divisor} |
| f_max_hz | output | 32 | Highest reachable serial clock |
| f_min_hz | output | 32 | Lowest reachable serial clock |

## Verification
The assertions assume that `start` is a clean synchronous pulse, and that a new start is only honoured while the unit is idle. Under that assumption the shared divider is never loaded in the middle of a division, and it never receives a zero divisor, because a zero request bypasses the ratio division. The stimulus drives `start` for exactly one cycle on the falling edge. It holds the inputs steady while the unit is idle, and deliberately fires a second start in mid-run only to show that it is dropped. The random requests are drawn in three bands: near the main clock, proportional to the main clock, and unrestricted. Together these reach the fast clamp, the fitting range and the slow clamp. Directed cases place the ratio exactly on the boundaries of the baud range.

// File: rtl/spibaud_pkg.sv
package spibaud_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_QUOT   = 3'd1,
    ST_SEARCH = 3'd2,
    ST_FMAX   = 3'd3,
    ST_FMIN   = 3'd4
  } calc_st_e;

  // Overall divide factor at the fastest setting: (2 << 0) * 2 * (brg_min + 1)
  function automatic int unsigned fast_factor(input int unsigned brg_min);
    return 4 * (brg_min + 1);
  endfunction

  // Overall divide factor at the slowest setting: (2 << div_max) * 2 * (brg_max + 1)
  function automatic int unsigned slow_factor(input int unsigned div_max,
                                              input int unsigned brg_max);
    return (2 << div_max) * 2 * (brg_max + 1);
  endfunction

endpackage

// File: rtl/spibaud_divider.sv
module spibaud_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc_q;   // dividend shifting out, quotient shifting in
  logic [W-1:0]  rem_q;
  logic [W-1:0]  dvd_l;
  logic [W-1:0]  dvs_l;
  logic [CW-1:0] cnt_q;

  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic [W-1:0]  acc_nx;
  logic [W-1:0]  rem_nx;

  always_comb begin
    shifted = {rem_q, acc_q[W-1]};
    trial   = shifted - {1'b0, dvs_l};
    if (!trial[W]) begin
      rem_nx = trial[W-1:0];
      acc_nx = {acc_q[W-2:0], 1'b1};
    end else begin
      rem_nx = shifted[W-1:0];
      acc_nx = {acc_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      dvd_l <= '0;
      dvs_l <= '0;
      cnt_q <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc_q <= dividend;
        rem_q <= '0;
        dvd_l <= dividend;
        dvs_l <= divisor;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        acc_q <= acc_nx;
        rem_q <= rem_nx;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) fin <= 1'b1;
      end
    end
  end

  assign quotient = acc_q;

  // Named internal events for the checks
  logic [2*W-1:0] recon;
  assign recon = ({{W{1'b0}}, acc_q} * {{W{1'b0}}, dvs_l}) + {{W{1'b0}}, rem_q};

  // R6
  no_zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> divisor != '0);

  // R7
  div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (recon == {{W{1'b0}}, dvd_l}) && (rem_q < dvs_l));

  // R2
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> cnt_q == '0);

endmodule

// File: rtl/spibaud_search.sv
module spibaud_search #(
  parameter int W       = 32,
  parameter int DIV_MAX = 3,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63,
  parameter int DIVW    = 2,
  parameter int BRGW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [W-1:0]    ratio,
  output logic [DIVW-1:0] div_o,
  output logic [BRGW-1:0] brg_o,
  output logic            fin
);
  localparam logic [W-1:0] Q_LO = W'(BRG_MIN + 1);
  localparam logic [W-1:0] Q_HI = W'(BRG_MAX + 1);

  // Baud divisor plus one for a given ratio and exponent
  function automatic logic [W-1:0] q_of(input logic [W-1:0] r, input logic [DIVW-1:0] d);
    return r >> ({{(32-DIVW){1'b0}}, d} + 32'd2);
  endfunction

  logic [W-1:0]    ratio_l;
  logic [DIVW-1:0] cur_d;
  logic            run;
  logic            hit_fast;
  logic            hit_slow;
  logic [W-1:0]    q;
  logic            too_fast;
  logic            fits;
  logic            last_step;

  assign q         = q_of(ratio_l, cur_d);
  assign too_fast  = q < Q_LO;
  assign fits      = q <= Q_HI;
  assign last_step = cur_d == DIVW'(DIV_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_l  <= '0;
      cur_d    <= '0;
      run      <= 1'b0;
      div_o    <= '0;
      brg_o    <= '0;
      fin      <= 1'b0;
      hit_fast <= 1'b0;
      hit_slow <= 1'b0;
    end else begin
      fin      <= 1'b0;
      hit_fast <= 1'b0;
      hit_slow <= 1'b0;
      if (go) begin
        ratio_l <= ratio;
        cur_d   <= '0;
        run     <= 1'b1;
      end else if (run) begin
        if (too_fast) begin
          div_o    <= cur_d;
          brg_o    <= BRGW'(BRG_MIN);
          fin      <= 1'b1;
          hit_fast <= 1'b1;
          run      <= 1'b0;
        end else if (fits) begin
          div_o <= cur_d;
          brg_o <= BRGW'(q - W'(1));
          fin   <= 1'b1;
          run   <= 1'b0;
        end else if (last_step) begin
          div_o    <= DIVW'(DIV_MAX);
          brg_o    <= BRGW'(BRG_MAX);
          fin      <= 1'b1;
          hit_slow <= 1'b1;
          run      <= 1'b0;
        end else begin
          cur_d <= cur_d + DIVW'(1);
        end
      end
    end
  end

  // R4
  fast_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fast |-> div_o == '0);

  // R5
  slow_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_slow |-> (div_o == DIVW'(DIV_MAX)) && (brg_o == BRGW'(BRG_MAX)));

  // R3
  brg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (brg_o >= BRGW'(BRG_MIN)) && (brg_o <= BRGW'(BRG_MAX)));

  // R2
  search_idle_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run);

endmodule

// File: rtl/spibaud_calc.sv
module spibaud_calc #(
  parameter int W       = 32,
  parameter int DIV_MAX = 3,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63,
  parameter int DIVW    = $clog2(DIV_MAX + 1),
  parameter int BRGW    = $clog2(BRG_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [W-1:0]         mclk_hz,
  input  logic [W-1:0]         sclk_hz,
  output logic                 busy,
  output logic                 done,
  output logic [DIVW-1:0]      div_sel,
  output logic [BRGW-1:0]      brg_sel,
  output logic [DIVW+BRGW-1:0] cfg_word,
  output logic [W-1:0]         f_max_hz,
  output logic [W-1:0]         f_min_hz
);
  import spibaud_pkg::*;

  localparam logic [W-1:0] FAST_DIV = W'(fast_factor(BRG_MIN));
  localparam logic [W-1:0] SLOW_DIV = W'(slow_factor(DIV_MAX, BRG_MAX) + 1);

  calc_st_e        st;
  logic [W-1:0]    m_l;
  logic [W-1:0]    s_l;
  logic            dv_go;
  logic [W-1:0]    dv_a;
  logic [W-1:0]    dv_b;
  logic [W-1:0]    dv_quo;
  logic            dv_fin;
  logic            srch_go;
  logic [DIVW-1:0] srch_div;
  logic [BRGW-1:0] srch_brg;
  logic            srch_fin;
  logic [DIVW-1:0] div_r;
  logic [BRGW-1:0] brg_r;
  logic [W-1:0]    fmax_r;
  logic [W-1:0]    fmin_r;

  spibaud_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (dv_go),
    .dividend (dv_a),
    .divisor  (dv_b),
    .quotient (dv_quo),
    .fin      (dv_fin)
  );

  spibaud_search #(
    .W(W), .DIV_MAX(DIV_MAX), .BRG_MIN(BRG_MIN), .BRG_MAX(BRG_MAX),
    .DIVW(DIVW), .BRGW(BRGW)
  ) u_search (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (srch_go),
    .ratio (dv_quo),
    .div_o (srch_div),
    .brg_o (srch_brg),
    .fin   (srch_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      m_l     <= '0;
      s_l     <= '0;
      dv_go   <= 1'b0;
      dv_a    <= '0;
      dv_b    <= '0;
      srch_go <= 1'b0;
      div_r   <= '0;
      brg_r   <= '0;
      fmax_r  <= '0;
      fmin_r  <= '0;
      done    <= 1'b0;
    end else begin
      dv_go   <= 1'b0;
      srch_go <= 1'b0;
      done    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            m_l   <= mclk_hz;
            s_l   <= sclk_hz;
            dv_go <= 1'b1;
            dv_a  <= mclk_hz;
            if (sclk_hz == '0) begin
              div_r <= DIVW'(DIV_MAX);
              brg_r <= BRGW'(BRG_MAX);
              dv_b  <= FAST_DIV;
              st    <= ST_FMAX;
            end else begin
              dv_b <= sclk_hz;
              st   <= ST_QUOT;
            end
          end
        end
        ST_QUOT: begin
          if (dv_fin) begin
            srch_go <= 1'b1;
            st      <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (srch_fin) begin
            div_r <= srch_div;
            brg_r <= srch_brg;
            dv_go <= 1'b1;
            dv_a  <= m_l;
            dv_b  <= FAST_DIV;
            st    <= ST_FMAX;
          end
        end
        ST_FMAX: begin
          if (dv_fin) begin
            fmax_r <= dv_quo;
            dv_go  <= 1'b1;
            dv_a   <= m_l;
            dv_b   <= SLOW_DIV;
            st     <= ST_FMIN;
          end
        end
        ST_FMIN: begin
          if (dv_fin) begin
            fmin_r <= dv_quo + W'(1);
            done   <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = st != ST_IDLE;
  assign div_sel  = div_r;
  assign brg_sel  = brg_r;
  assign cfg_word = {div_r, brg_r};
  assign f_max_hz = fmax_r;
  assign f_min_hz = fmin_r;

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(m_l) && $stable(s_l));

  // R6
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && s_l == '0) |-> (div_sel == DIVW'(DIV_MAX)) && (brg_sel == BRGW'(BRG_MAX)));

  // R3
  result_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (brg_sel >= BRGW'(BRG_MIN)) && (brg_sel <= BRGW'(BRG_MAX)));

endmodule

// File: tb/spibaud_calc_bench.sv
module spibaud_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mclk_hz = '0;
  logic [31:0] sclk_hz = '0;
  logic        busy;
  logic        done;
  logic [1:0]  div_sel;
  logic [5:0]  brg_sel;
  logic [7:0]  cfg_word;
  logic [31:0] f_max_hz;
  logic [31:0] f_min_hz;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spibaud_calc u_spibaud_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .mclk_hz(mclk_hz), .sclk_hz(sclk_hz),
    .busy(busy), .done(done), .div_sel(div_sel), .brg_sel(brg_sel),
    .cfg_word(cfg_word), .f_max_hz(f_max_hz), .f_min_hz(f_min_hz)
  );

  function automatic logic [7:0] ref_cfg(input int unsigned m, input int unsigned s);
    int unsigned q;
    if (s == 0) return {2'd3, 6'd63};
    for (int d = 0; d < 4; d++) begin
      q = (m / s) / (32'd4 << d);
      if (q < 5) return {2'(d), 6'd4};
      if (q <= 64) return {2'(d), 6'(q - 1)};
    end
    return {2'd3, 6'd63};
  endfunction

  function automatic string region(input int unsigned m, input int unsigned s);
    logic [7:0] c;
    c = ref_cfg(m, s);
    if (s == 0) return "R6";
    if ((m / s) / 4 < 5) return "R4";
    if (c == {2'd3, 6'd63} && ((m / s) / 32) > 64) return "R5";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] m, input logic [31:0] s, input bit intf,
                     output int lat);
    logic [7:0] e;
    bit bad_busy;
    e = ref_cfg(m, s);
    @(negedge clk);
    mclk_hz = m; sclk_hz = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    bad_busy = 0;
    while (!done && lat < 2000) begin
      if (!busy) bad_busy = 1;
      if (intf && lat == 5) begin
        mclk_hz = ~m; sclk_hz = s + 32'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R2 busy during run", {63'd0, bad_busy}, 64'd0);
    chk("R2 done seen", {63'd0, done}, 64'd1);
    chk("R2 busy low at done", {63'd0, busy}, 64'd0);
    chk({region(m, s), intf ? " R10 cfg" : " cfg"}, {56'd0, cfg_word}, {56'd0, e});
    chk("R9 div field", {62'd0, div_sel}, {62'd0, e[7:6]});
    chk("R9 brg field", {58'd0, brg_sel}, {58'd0, e[5:0]});
    chk("R7 fmax", {32'd0, f_max_hz}, {32'd0, m / 32'd20});
    chk("R8 fmin", {32'd0, f_min_hz}, {32'd0, m / 32'd2049 + 32'd1});
    @(negedge clk);
    chk("R2 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected<150000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lat0, lat1, lat;
    logic [31:0] m, s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 cfg", {56'd0, cfg_word}, 64'd0);
    chk("R1 fmax", {32'd0, f_max_hz}, 64'd0);
    chk("R1 fmin", {32'd0, f_min_hz}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners: ratio 4*64 (upper fit edge), 4*65, 20, 19
    run(32'd256, 32'd1, 0, lat);          // R3 q=64 -> div0 brg63
    run(32'd2600, 32'd10, 0, lat);        // R3 q=65 -> div1 brg31
    run(32'd200, 32'd10, 0, lat);         // R3 q=5 -> div0 brg4
    run(32'd190, 32'd10, 0, lat);         // R4 q=4 -> fast clamp
    run(32'd48000000, 32'd12000000, 0, lat); // R4
    run(32'd48000000, 32'd100000, 0, lat);   // R3 div1 brg59
    run(32'd48000000, 32'd1000, 0, lat);     // R5 slow clamp
    run(32'd0, 32'd1, 0, lat);               // R4 zero main clock
    run(32'hFFFF_FFFF, 32'd1, 0, lat);       // R5 widest ratio
    // R6 zero request is faster by at least one division
    run(32'd48000000, 32'd0, 0, lat0);
    run(32'd48000000, 32'd1000, 0, lat1);
    chk("R6 zero request latency", {63'd0, lat0 + 32 <= lat1}, 64'd1);
    // R10 restart attempts during a run
    run(32'd33000000, 32'd250000, 1, lat);
    run(32'd1000000, 32'd0, 1, lat);

    for (int i = 0; i < 80; i++) begin
      m = $urandom();
      case ($urandom_range(0, 2))
        0: s = $urandom_range(100, 1);
        1: s = m / $urandom_range(4000, 4) + $urandom_range(3, 0);
        default: s = $urandom();
      endcase
      run(m, s, (i % 9) == 4, lat);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule